// File: doc/BRIEF.md
# Cascadable Serial LCD Segment Driver Core

This block is the digital core of a static LCD segment driver. Segment data arrives one bit at a time on a serial input. While the active-low select is asserted, each falling edge of the shift clock moves that bit into a 38-stage shift register. A load strobe copies the register into a parallel output latch. While the strobe is held high the latch follows the register, so it is transparent.

Every segment output is its latched bit XORed with a backplane level. A latched 1 drives the segment in antiphase with the backplane, which turns it on. A latched 0 keeps the segment in phase with the backplane, which leaves it dark. The backplane comes from one of two sources, picked by a mode input:
- Self-oscillating mode: the display clock divided by 256 in an 8-bit counter, with a 50% duty cycle.
- External mode: the display clock itself, retimed by one system clock.

To build a display wider than 38 segments, drivers are chained. The serial output of one driver feeds the serial input of the next, and all of them share the shift clock, load and select lines. A parameter picks which stage feeds the serial output: 30, 32, 34 or 38. That output is retimed on the rising edge of the shift clock, which gives the next driver half a shift period of margin.

All logic runs on one system clock `clk`, which samples the shift and display clocks and detects their edges. A synchronous active-low reset clears the register, the latch, the divider and the serial output.

Top module: `lcd_seg_core`

## Requirements
- R1: In a system clock cycle where the sampled shift clock `sck` goes from 1 to 0 and `cs_n` is 0, the register shifts by one. The bit on `sdi` enters stage 1, and each stage k takes the old value of stage k-1. Stage k is the bit behind `seg[k-1]`.
- R2: While `cs_n` is 1, the shift register keeps its contents through any number of `sck` falling edges.
- R3: On a rising edge of `sck`, `sdo` takes the value of stage TAP (default 38). At all other times `sdo` holds its value.
- R4: In every cycle where `load` is 1, the latch takes the register contents, so a load held high across shifting keeps the latch following the register. While `load` is 0 the latch holds.
- R5: Each `seg[i]` equals latch bit i XOR `bp`. A latched 1 is therefore antiphase with the backplane, and a latched 0 is in phase with it.
- R6: With `self_osc` = 1, `bp` is the most significant bit of an 8-bit counter of rising edges on `dclk`. After reset, `bp` first goes to 1 on the 128th rise and returns to 0 on the 256th.
- R7: With `self_osc` = 0, `bp` equals the value `dclk` had one system clock earlier.
- R8: While `rst_n` is 0 at a clock edge, the register, the latch, the divider and `sdo` are all cleared to 0. With `self_osc` = 1 this makes `bp` and every `seg` bit 0.
- R9: If two drivers share `sck`, `cs_n` and `load`, and the `sdo` of the first feeds the `sdi` of the second, they act as one 76-stage register. The second driver holds stages 39 to 76.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock that samples every input |
| rst_n | input | 1 | Synchronous active-low reset |
| sdi | input | 1 | Serial segment data input |
| sck | input | 1 | Shift clock: shifts on the fall, retimes `sdo` on the rise |
| cs_n | input | 1 | Active-low select that enables shifting |
| load | input | 1 | Latch strobe, transparent while high |
| dclk | input | 1 | Display clock |
| self_osc | input | 1 | 1 = backplane from the divided clock, 0 = backplane follows `dclk` |
| sdo | output | 1 | Serial cascade output from stage TAP |
| seg | output | NSEG | Segment levels, latch XOR backplane |
| bp | output | 1 | Backplane level |

## Verification
The assertions assume that `sck` and `dclk` change slowly compared with `clk`, so every level lasts at least one system clock and no edge is lost. They also assume that `sck` is low while reset is asserted, so that reset does not create a false edge. The bench drives every input on the falling edge of `clk` and holds each shift-clock and display-clock phase for one full system cycle. It keeps `sck` low through both reset pulses. Random data from a fixed seed fills the whole 76-stage chain. Directed steps then cover a load held open while shifting, shifting with the select inactive, the divider's 128th and 256th edges, and a switch to external mode.

// File: rtl/lcd_seg_core.sv
module lcd_seg_core #(
  parameter int NSEG = 38,
  parameter int TAP  = 38,
  parameter int DIVW = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            sdi,
  input  logic            sck,
  input  logic            cs_n,
  input  logic            load,
  input  logic            dclk,
  input  logic            self_osc,
  output logic            sdo,
  output logic [NSEG-1:0] seg,
  output logic            bp
);
  localparam int TIDX = TAP - 1;

  logic            sck_q, dclk_q, sdo_q;
  logic            sck_fall, sck_rise, dclk_rise;
  logic [NSEG-1:0] sr, lat;
  logic [DIVW-1:0] div;

  assign sck_fall  = sck_q & ~sck;
  assign sck_rise  = ~sck_q & sck;
  assign dclk_rise = ~dclk_q & dclk;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sck_q  <= 1'b0;
      dclk_q <= 1'b0;
    end else begin
      sck_q  <= sck;
      dclk_q <= dclk;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)                   sr <= '0;
    else if (sck_fall && !cs_n)   sr <= {sr[NSEG-2:0], sdi};
  end

  always_ff @(posedge clk) begin
    if (!rst_n)        sdo_q <= 1'b0;
    else if (sck_rise) sdo_q <= sr[TIDX];
  end

  always_ff @(posedge clk) begin
    if (!rst_n)    lat <= '0;
    else if (load) lat <= sr;
  end

  always_ff @(posedge clk) begin
    if (!rst_n)         div <= '0;
    else if (dclk_rise) div <= div + 1'b1;
  end

  assign sdo = sdo_q;
  assign bp  = self_osc ? div[DIVW-1] : dclk_q;
  assign seg = lat ^ {NSEG{bp}};
endmodule

// File: rtl/lcd_seg_core_chk.sv
module lcd_seg_core_chk #(
  parameter int NSEG = 38,
  parameter int TAP  = 38
) (
  input logic            clk,
  input logic            rst_n,
  input logic            sdi,
  input logic            sck,
  input logic            sck_q,
  input logic            cs_n,
  input logic            load,
  input logic            dclk,
  input logic            dclk_rise,
  input logic            self_osc,
  input logic [NSEG-1:0] sr,
  input logic [NSEG-1:0] lat,
  input logic            sdo,
  input logic            bp
);
  AST_SHIFT_IN: assert property (@(posedge clk) disable iff (!rst_n)
    (sck_q && !sck && !cs_n) |=> (sr[0] == $past(sdi) && sr[NSEG-1:1] == $past(sr[NSEG-2:0]))); // R1
  AST_HOLD_DESEL: assert property (@(posedge clk) disable iff (!rst_n)
    cs_n |=> $stable(sr)); // R2
  AST_SDO_TAP: assert property (@(posedge clk) disable iff (!rst_n)
    (!sck_q && sck) |=> (sdo == $past(sr[TAP-1]))); // R3
  AST_SDO_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !(!sck_q && sck) |=> $stable(sdo)); // R3
  AST_LATCH_OPEN: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> (lat == $past(sr))); // R4
  AST_LATCH_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !load |=> $stable(lat)); // R4
  AST_DIV_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    (self_osc && !dclk_rise) |=> (!self_osc || $stable(bp))); // R6
  AST_EXT_FOLLOW: assert property (@(posedge clk) disable iff (!rst_n)
    !self_osc |=> (self_osc || bp == $past(dclk))); // R7
endmodule

bind lcd_seg_core lcd_seg_core_chk #(.NSEG(NSEG), .TAP(TAP)) u_chk (
  .clk(clk), .rst_n(rst_n), .sdi(sdi), .sck(sck), .sck_q(sck_q), .cs_n(cs_n),
  .load(load), .dclk(dclk), .dclk_rise(dclk_rise), .self_osc(self_osc),
  .sr(sr), .lat(lat), .sdo(sdo), .bp(bp)
);

// File: tb/lcd_seg_core_tb.sv
module lcd_seg_core_tb;
  localparam int N = 38;

  logic clk = 1'b0;
  logic rst_n = 1'b0, sdi = 1'b0, sck = 1'b0, cs_n = 1'b0, load = 1'b0;
  logic dclk = 1'b0, self_osc = 1'b1;
  logic sdo_a, sdo_b, sdo_c, bp_a, bp_b, bp_c;
  logic [N-1:0] seg_a, seg_b, seg_c;

  int tests = 0, fails = 0;
  logic [2*N-1:0] ch;
  logic [N-1:0] la, lb;
  int cnt;
  bit done = 0;

  always #4 clk = ~clk;

  lcd_seg_core u_dut (.clk(clk), .rst_n(rst_n), .sdi(sdi), .sck(sck), .cs_n(cs_n),
    .load(load), .dclk(dclk), .self_osc(self_osc), .sdo(sdo_a), .seg(seg_a), .bp(bp_a));
  lcd_seg_core u_nxt (.clk(clk), .rst_n(rst_n), .sdi(sdo_a), .sck(sck), .cs_n(cs_n),
    .load(load), .dclk(dclk), .self_osc(self_osc), .sdo(sdo_b), .seg(seg_b), .bp(bp_b));
  lcd_seg_core #(.TAP(30)) u_t30 (.clk(clk), .rst_n(rst_n), .sdi(sdi), .sck(sck), .cs_n(cs_n),
    .load(load), .dclk(dclk), .self_osc(self_osc), .sdo(sdo_c), .seg(seg_c), .bp(bp_c));

  task automatic tick();
    @(negedge clk);
  endtask

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s act=%0h exp=%0h", req, act, exp);
    end
  endtask

  function automatic logic ebp();
    logic [7:0] c = cnt[7:0];
    return self_osc ? c[7] : dclk;
  endfunction

  task automatic chk_segs(input string req);
    chk(req, {26'd0, seg_a}, {26'd0, la ^ {N{ebp()}}});
    chk(req, {26'd0, seg_b}, {26'd0, lb ^ {N{ebp()}}});
  endtask

  task automatic shift_bit(input logic b, input bit check_sdo);
    sdi = b; sck = 1'b1; tick();
    if (check_sdo) begin
      chk("R3 sdo tap38", {63'd0, sdo_a}, {63'd0, ch[N-1]});
      chk("R3 sdo tap30", {63'd0, sdo_c}, {63'd0, ch[29]});
    end
    sck = 1'b0; tick();
    if (!cs_n) ch = {ch[2*N-2:0], b};
  endtask

  task automatic do_load();
    load = 1'b1; tick();
    la = ch[N-1:0]; lb = ch[2*N-1:N];
    load = 1'b0; tick();
  endtask

  task automatic dclk_pulse();
    dclk = 1'b1; tick(); cnt++;
    dclk = 1'b0; tick();
  endtask

  task automatic do_reset();
    rst_n = 1'b0; sck = 1'b0; tick(); tick();
    ch = '0; la = '0; lb = '0; cnt = 0;
  endtask

  initial begin
    void'($urandom(32'h5eed_0107));
    ch = '0; la = '0; lb = '0; cnt = 0;
    do_reset();
    chk("R8 reset sdo", {63'd0, sdo_a}, 64'd0);
    chk("R8 reset bp", {63'd0, bp_a}, 64'd0);
    chk("R8 reset seg", {26'd0, seg_a}, 64'd0);
    rst_n = 1'b1; tick();

    for (int i = 0; i < 2*N; i++) shift_bit(1'($urandom), (i % 7) == 0);
    do_load();
    chk_segs("R9 R5 chain after 76 bits");
    chk("R9 chain tail", {26'd0, u_nxt.seg}, {26'd0, ch[2*N-1:N]});

    for (int i = 0; i < 10; i++) shift_bit(1'($urandom), 1);
    chk("R4 latch held without load", {26'd0, seg_a}, {26'd0, la});
    do_load();
    chk_segs("R1 R5 after more shifts");

    cs_n = 1'b1;
    for (int i = 0; i < 6; i++) shift_bit(~ch[i], 0);
    cs_n = 1'b0;
    do_load();
    chk_segs("R2 deselected shifts ignored");

    load = 1'b1; tick();
    for (int i = 0; i < 4; i++) begin
      shift_bit(1'($urandom), 0); tick();
      la = ch[N-1:0]; lb = ch[2*N-1:N];
      chk_segs("R4 transparent latch");
    end
    load = 1'b0; tick();

    shift_bit(1'b1, 1); shift_bit(1'b0, 1); shift_bit(1'b1, 1);
    do_load();
    chk("R1 newest bits at stage 1..3", {61'd0, seg_a[2:0]}, {61'd0, 3'b101});

    for (int i = 0; i < 127; i++) dclk_pulse();
    chk("R6 bp low after 127", {63'd0, bp_a}, 64'd0);
    chk_segs("R5 phase low");
    dclk_pulse();
    chk("R6 bp high at 128", {63'd0, bp_a}, 64'd1);
    chk_segs("R5 phase high");
    for (int i = 0; i < 127; i++) dclk_pulse();
    chk("R6 bp still high at 255", {63'd0, bp_a}, 64'd1);
    dclk_pulse();
    chk("R6 bp low at 256", {63'd0, bp_a}, 64'd0);

    self_osc = 1'b0;
    dclk = 1'b1; tick(); cnt++;
    chk("R7 ext bp high", {63'd0, bp_a}, 64'd1);
    chk_segs("R7 R5 ext high");
    dclk = 1'b0; tick();
    chk("R7 ext bp low", {63'd0, bp_a}, 64'd0);
    chk_segs("R7 R5 ext low");
    self_osc = 1'b1; tick();

    do_reset();
    chk("R8 mid reset seg", {26'd0, seg_a}, 64'd0);
    chk("R8 mid reset sdo", {62'd0, sdo_b, sdo_a}, 64'd0);
    chk("R8 mid reset bp", {63'd0, bp_a}, 64'd0);
    rst_n = 1'b1; tick();
    shift_bit(1'b1, 1);
    do_load();
    chk_segs("R8 R1 after reset");

    done = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    #(8 * 200000);
    if (!done) begin
      tests++; fails++;
      $display("FAIL watchdog R1 act=hung exp=done");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end
endmodule